// File: doc/BRIEF.md
# Alternating-Slot Receive Frame Acceptor

This block sits after a receive byte stream and decides which frames to keep. Each frame arrives one byte per beat, with a valid strobe and a marker on the final byte. While the frame streams in, the block compares its destination address against a configured station address and counts its length. It also writes the bytes into a staging area that the host cannot see. On the final byte it makes one decision. If the frame passes the address filter, is shorter than the length limit and finds the current slot empty, the staged bytes become that slot's buffer. The slot is marked full, and the block moves on to the other slot when alternation is enabled.

The host reaches the two slots over a simple 32-bit register bus. Slot 0 occupies the byte window 0x1000–0x17FF and slot 1 occupies 0x1800–0x1FFF. The last word of each window is that slot's control/status word. The host drains a slot and then frees it by writing its control word with the full flag clear. A one-cycle interrupt pulse announces an accepted frame when both the slot's interrupt enable and the global enable are set.

Top module: `rx_pingpong_acceptor`

## Requirements
- R1: A frame passes the address filter when bit 7 of its first byte is 1 (group address), or when its first six bytes equal `station_addr` taken from bits 47:40 down to bits 7:0. A frame that passes neither test is dropped, and the dropped frame changes no buffer word, control word, interrupt or ready flag.
- R2: A frame that ends while the current slot's full flag is set is refused. The refusal changes no buffer word or control word, raises no interrupt, and leaves `rx_ready` low.
- R3: A frame of `MAX_LEN` bytes or more (default 2020) is rejected with no visible effect. A frame of `MAX_LEN`-1 bytes is accepted in full.
- R4: On acceptance, frame byte i becomes readable at slot base + 4*(i/4), in bit lane 8*(i%4) (little-endian). Lanes past the final byte of its last word read 0. The slot's full flag (bit 0 of its control word) is set in the same clock edge that takes the final byte.
- R5: On acceptance, `irq_pulse` is high for exactly one cycle, starting at the edge that takes the final byte. This happens only if the slot's interrupt-enable (bit 3 of its control word) and `glb_irq_en` are both 1.
- R6: With `PINGPONG`=1 the current slot toggles after every accepted frame. With `PINGPONG`=0 slot 0 is always used.
- R7: After reset the current slot is 0, both control words read 0, `rx_ready` is 1 and `irq_pulse` is 0.
- R8: `rx_ready` is high exactly when the current slot's full flag is clear. A host write to a control word (slot 0 at 0x17FC, slot 1 at 0x1FFC) stores bits 0 and 3, and all other bits read 0. Writing bit 0 as 0 frees the slot.
- R9: A frame shorter than six bytes is dropped even if its first byte carries the group bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Frame byte present this cycle |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of a frame |
| station_addr | input | 48 | Station address; first byte on bits 47:40 |
| glb_irq_en | input | 1 | Global interrupt enable |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 13 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational) |
| rx_ready | output | 1 | Current slot can take a frame |
| irq_pulse | output | 1 | One-cycle interrupt pulse on acceptance |

## Verification
Several internal faults show up at the ports one cycle after the final byte of a frame. A wrong slot pointer or full flag shows on `rx_ready` and on the control word reads. A wrong filter verdict shows the same way. A fault in the bank remapping shows as stale or foreign bytes when the host reads a slot buffer. This also catches a dropped frame that leaked into a visible buffer, because the old contents would have changed. The bench sends a second, non-alternating instance the same stimulus, so a slot pointer that toggles when it should not will disagree with it on the next frame.

// File: rtl/rxa_pkg.sv
// Shared constants and types for the receive frame acceptor.
package rxa_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int NUM_SLOTS  = 2;
    localparam int NUM_BANKS  = NUM_SLOTS + 1;
    localparam int ADDR_BYTES = 6;
    localparam int FULL_BIT   = 0;
    localparam int IEN_BIT    = 3;
    typedef logic [1:0] bank_t;
endpackage

// File: rtl/rxa_dest_filter.sv
// Byte-serial destination filter. It compares the first six bytes of a frame
// with the station address and captures the group bit of byte 0.
// Assumes: idx is the byte index of the current beat and returns to 0 after last.
module rxa_dest_filter #(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat,
    input  logic             last,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       data,
    input  logic [47:0]      station,
    output logic             pass_now
);
    import rxa_pkg::*;

    logic       grp_q, match_q;
    logic [7:0] exp_byte;
    logic       eq, grp_now, match_now;

    // Select the station byte expected at this index.
    always_comb begin
        case (idx)
            IDX_W'(0): exp_byte = station[47:40];
            IDX_W'(1): exp_byte = station[39:32];
            IDX_W'(2): exp_byte = station[31:24];
            IDX_W'(3): exp_byte = station[23:16];
            IDX_W'(4): exp_byte = station[15:8];
            IDX_W'(5): exp_byte = station[7:0];
            default:   exp_byte = 8'h00;
        endcase
    end

    // Combine the running verdict with the byte on the bus this cycle.
    always_comb begin
        eq        = (data == exp_byte);
        grp_now   = (idx == '0) ? data[7] : grp_q;
        if (idx == '0)
            match_now = eq;
        else if (idx < IDX_W'(ADDR_BYTES))
            match_now = match_q & eq;
        else
            match_now = match_q;
        pass_now  = (idx >= IDX_W'(ADDR_BYTES - 1)) && (grp_now || match_now);
    end

    // Hold the verdict between beats; clear it when a frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_q   <= 1'b0;
            match_q <= 1'b0;
        end else if (beat) begin
            if (last) begin
                grp_q   <= 1'b0;
                match_q <= 1'b0;
            end else begin
                grp_q   <= grp_now;
                match_q <= match_now;
            end
        end
    end
endmodule

// File: rtl/rxa_bank_store.sv
// Three equal buffer banks with byte-lane writes and a combinational word read.
// Writing lane 0 clears the other lanes of that word, so partial tail words are clean.
// Assumes: the writer targets only the bank not mapped to a slot.
module rxa_bank_store #(
    parameter int WORDS = 505,
    parameter int WIX_W = 9,
    parameter int RD_W  = 9
) (
    input  logic             clk,
    input  logic             wr_en,
    input  rxa_pkg::bank_t   wr_bank,
    input  logic [WIX_W-1:0] wr_word,
    input  logic [1:0]       wr_lane,
    input  logic [7:0]       wr_byte,
    input  rxa_pkg::bank_t   rd_bank,
    input  logic [RD_W-1:0]  rd_word,
    output logic [31:0]      rd_data
);
    import rxa_pkg::*;

    localparam int DEPTH = NUM_BANKS * WORDS;
    localparam int AW    = $clog2(DEPTH);

    logic [3:0][7:0] mem [DEPTH];
    logic [AW-1:0]   wa, ra;
    logic            rd_ok;

    // Flatten bank and word into one memory index.
    always_comb begin
        wa    = AW'(wr_bank) * AW'(WORDS) + AW'(wr_word);
        ra    = AW'(rd_bank) * AW'(WORDS) + AW'(rd_word);
        rd_ok = (int'(rd_word) < WORDS);
    end

    // Store one byte per beat.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_lane == 2'd0)
                mem[wa] <= {24'h000000, wr_byte};
            else
                mem[wa][wr_lane] <= wr_byte;
        end
    end

    // Return the addressed word, or zero past the buffer end.
    always_comb rd_data = rd_ok ? mem[ra] : 32'h0;
endmodule

// File: rtl/rxa_slot_ctrl.sv
// Per-slot control and status, the current slot pointer, the slot-to-bank map
// and the interrupt pulse.
// Assumes: commit is only raised when the current slot is empty.
module rxa_slot_ctrl #(
    parameter bit PINGPONG = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           commit,
    input  logic           ctrl_we,
    input  logic           ctrl_slot,
    input  logic           wr_full,
    input  logic           wr_ien,
    input  logic           glb_irq_en,
    output logic           cur,
    output logic [1:0]     full,
    output logic [1:0]     ien,
    output rxa_pkg::bank_t map0,
    output rxa_pkg::bank_t map1,
    output rxa_pkg::bank_t spare,
    output logic           irq_pulse
);
    import rxa_pkg::*;

    bank_t map_q [NUM_SLOTS];
    logic  cur_q, irq_q;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic f_q, i_q;
        // Host writes set both flags; acceptance sets the full flag last.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                f_q <= 1'b0;
                i_q <= 1'b0;
            end else begin
                if (ctrl_we && (ctrl_slot == 1'(g))) begin
                    f_q <= wr_full;
                    i_q <= wr_ien;
                end
                if (commit && (cur_q == 1'(g)))
                    f_q <= 1'b1;
            end
        end
        assign full[g] = f_q;
        assign ien[g]  = i_q;
    end

    assign spare = bank_t'(2'd3 - map_q[0] - map_q[1]);

    // Move the slot pointer and swing the committed slot onto the staging bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q    <= 1'b0;
            map_q[0] <= bank_t'(0);
            map_q[1] <= bank_t'(1);
        end else if (commit) begin
            map_q[cur_q] <= spare;
            if (PINGPONG)
                cur_q <= ~cur_q;
        end
    end

    // Register the interrupt pulse for acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= commit && ien[cur_q] && glb_irq_en;
    end

    assign cur       = cur_q;
    assign map0      = map_q[0];
    assign map1      = map_q[1];
    assign irq_pulse = irq_q;
endmodule

// File: rtl/rx_pingpong_acceptor.sv
// Receive frame acceptor with two host-visible slots that it fills alternately.
// It tracks the length, filters on the destination, stages bytes in a spare bank
// and commits them by remapping at the final byte.
// Assumes: one byte per in_valid beat; host reads are combinational.
module rx_pingpong_acceptor #(
    parameter int MAX_LEN  = 2020,
    parameter bit PINGPONG = 1'b1,
    parameter int ADDR_W   = 13
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    input  logic [47:0] station_addr,
    input  logic        glb_irq_en,
    input  logic        host_we,
    input  logic [12:0] host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        rx_ready,
    output logic        irq_pulse
);
    import rxa_pkg::*;

    localparam int CAP_BYTES = MAX_LEN - 1;
    localparam int CAP_WORDS = (CAP_BYTES + WORD_BYTES - 1) / WORD_BYTES;
    localparam int IDX_W     = $clog2(MAX_LEN);
    localparam int WIX_W     = $clog2(CAP_WORDS);
    localparam int WIN_W     = ADDR_W - 4;

    logic [IDX_W-1:0] idx_q;
    logic             pass_now, too_long, store_en, commit;
    logic             cur;
    logic [1:0]       full, ien;
    bank_t            map0, map1, spare, rd_bank;
    logic             in_rx, h_slot, is_ctrl, ctrl_we;
    logic [WIN_W-1:0] h_word;
    logic [31:0]      buf_word;
    logic             unused_bits;

    assign unused_bits = ^{host_wdata[31:4], host_wdata[2:1], host_addr[1:0]};

    // Count bytes within the frame, saturating at the length limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (in_valid) begin
            if (in_last)
                idx_q <= '0;
            else if (idx_q != IDX_W'(CAP_BYTES))
                idx_q <= idx_q + 1'b1;
        end
    end

    rxa_dest_filter #(.IDX_W(IDX_W)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .beat     (in_valid),
        .last     (in_last),
        .idx      (idx_q),
        .data     (in_data),
        .station  (station_addr),
        .pass_now (pass_now)
    );

    // Decide staging and commit for the current beat.
    always_comb begin
        too_long = (idx_q >= IDX_W'(CAP_BYTES));
        store_en = in_valid && !too_long;
        commit   = in_valid && in_last && pass_now && !too_long && !full[cur];
    end

    // Decode the host address into slot, word and control access.
    always_comb begin
        in_rx   = host_addr[ADDR_W-1];
        h_slot  = host_addr[ADDR_W-2];
        h_word  = host_addr[ADDR_W-3:2];
        is_ctrl = (h_word == {WIN_W{1'b1}});
        ctrl_we = host_we && in_rx && is_ctrl;
        rd_bank = h_slot ? map1 : map0;
    end

    rxa_bank_store #(.WORDS(CAP_WORDS), .WIX_W(WIX_W), .RD_W(WIN_W)) u_store (
        .clk     (clk),
        .wr_en   (store_en),
        .wr_bank (spare),
        .wr_word (WIX_W'(idx_q >> 2)),
        .wr_lane (idx_q[1:0]),
        .wr_byte (in_data),
        .rd_bank (rd_bank),
        .rd_word (h_word),
        .rd_data (buf_word)
    );

    rxa_slot_ctrl #(.PINGPONG(PINGPONG)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .ctrl_we    (ctrl_we),
        .ctrl_slot  (h_slot),
        .wr_full    (host_wdata[FULL_BIT]),
        .wr_ien     (host_wdata[IEN_BIT]),
        .glb_irq_en (glb_irq_en),
        .cur        (cur),
        .full       (full),
        .ien        (ien),
        .map0       (map0),
        .map1       (map1),
        .spare      (spare),
        .irq_pulse  (irq_pulse)
    );

    // Drive the host read data from the control word or a buffer word.
    always_comb begin
        if (!in_rx)
            host_rdata = 32'h0;
        else if (is_ctrl)
            host_rdata = {28'h0, ien[h_slot], 2'b00, full[h_slot]};
        else
            host_rdata = buf_word;
    end

    assign rx_ready = !full[cur];
endmodule

// File: rtl/rxa_checker.sv
// Temporal checks on the acceptor's ports, attached to every instance by bind.
module rxa_checker (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_last,
    input logic glb_irq_en,
    input logic host_we,
    input logic rx_ready,
    input logic irq_pulse
);
    logic seen_q;

    // Mark that at least one edge has passed.
    always_ff @(posedge clk) seen_q <= 1'b1;

    AST_RESET_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(!rst_n)) |-> rx_ready);                              // R7
    AST_IRQ_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(in_valid && in_last && glb_irq_en));              // R5
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);                                            // R5
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && !host_we) |=> !rx_ready);                               // R2
    AST_READY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $fell(rx_ready)) |-> ($past(in_valid && in_last) || $past(host_we))); // R4
endmodule

bind rx_pingpong_acceptor rxa_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .glb_irq_en (glb_irq_en),
    .host_we    (host_we),
    .rx_ready   (rx_ready),
    .irq_pulse  (irq_pulse)
);

// File: tb/tb_rx_pingpong_acceptor.sv
module tb_rx_pingpong_acceptor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_last = 1'b0, glb_irq_en = 1'b0, host_we = 1'b0;
    logic [7:0]  in_data = 8'h0;
    logic [47:0] station_addr = 48'h02_11_22_33_44_55;
    logic [12:0] host_addr = 13'h0;
    logic [31:0] host_wdata = 32'h0;
    logic [31:0] rdata_a, rdata_b;
    logic        ready_a, ready_b, irq_a, irq_b;
    logic [7:0]  fbuf [0:2047];
    int          n_chk = 0, n_bad = 0, irqs_a = 0, irqs_b = 0;
    logic [31:0] ra, rb;

    always #10 clk = ~clk;

    rx_pingpong_acceptor dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .station_addr(station_addr), .glb_irq_en(glb_irq_en), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(rdata_a),
        .rx_ready(ready_a), .irq_pulse(irq_a));

    rx_pingpong_acceptor #(.PINGPONG(1'b0)) dut_fixed (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .station_addr(station_addr), .glb_irq_en(glb_irq_en), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(rdata_b),
        .rx_ready(ready_b), .irq_pulse(irq_b));

    always @(negedge clk) if (rst_n) begin
        if (irq_a) irqs_a++;
        if (irq_b) irqs_b++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1;
            in_data  = fbuf[i];
            in_last  = (i == n - 1);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        @(negedge clk);
        #2;
    endtask

    task automatic hwrite(input logic [12:0] a, input logic [31:0] d);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
        #2;
    endtask

    task automatic hread(input logic [12:0] a);
        host_addr = a;
        #1;
        ra = rdata_a;
        rb = rdata_b;
    endtask

    task automatic load_unicast(input int n, input logic [7:0] tail0);
        for (int i = 0; i < 6; i++) fbuf[i] = station_addr[47 - 8*i -: 8];
        for (int i = 6; i < n; i++) fbuf[i] = tail0 + 8'(i - 6);
    endtask

    task automatic t_reset;
        chk("R7 ready", {31'b0, ready_a}, 32'h1);
        chk("R7 ready fixed", {31'b0, ready_b}, 32'h1);
        chk("R7 irq", {31'b0, irq_a}, 32'h0);
        hread(13'h17FC); chk("R7 ctrl0", ra, 32'h0);
        hread(13'h1FFC); chk("R7 ctrl1", ra, 32'h0);
    endtask

    task automatic t_unicast;
        hwrite(13'h17FC, 32'h8);
        hread(13'h17FC); chk("R8 ctrl0 ien", ra, 32'h8);
        glb_irq_en = 1'b1;
        load_unicast(10, 8'hA0);
        send(10);
        chk("R5 irq count", 32'(irqs_a), 32'd1);
        chk("R5 irq count fixed", 32'(irqs_b), 32'd1);
        hread(13'h17FC); chk("R4 ctrl0 full", ra, 32'h9);
        hread(13'h1000); chk("R4 word0", ra, 32'h33221102);
        hread(13'h1004); chk("R4 word1", ra, 32'hA1A05544);
        hread(13'h1008); chk("R4 tail word", ra, 32'h0000A3A2);
        chk("R6 ready after toggle", {31'b0, ready_a}, 32'h1);
        chk("R6 ready fixed", {31'b0, ready_b}, 32'h0);
    endtask

    task automatic t_group;
        for (int i = 0; i < 6; i++) fbuf[i] = 8'hFF;
        fbuf[6] = 8'hB0; fbuf[7] = 8'hB1;
        send(8);
        chk("R5 no irq ien0", 32'(irqs_a), 32'd1);
        hread(13'h1FFC); chk("R1 group ctrl1", ra, 32'h1);
        chk("R2 fixed refused ctrl1", rb, 32'h0);
        hread(13'h1804); chk("R1 group word1", ra, 32'hB1B0FFFF);
        chk("R8 ready low", {31'b0, ready_a}, 32'h0);
    endtask

    task automatic t_full;
        load_unicast(8, 8'hC0);
        send(8);
        hread(13'h1004); chk("R2 buffer kept", ra, 32'hA1A05544);
        hread(13'h17FC); chk("R2 ctrl kept", ra, 32'h9);
        chk("R2 no irq", 32'(irqs_a), 32'd1);
        chk("R2 ready low", {31'b0, ready_a}, 32'h0);
    endtask

    task automatic t_free;
        hwrite(13'h17FC, 32'h8);
        chk("R8 freed ready", {31'b0, ready_a}, 32'h1);
        chk("R8 freed ready fixed", {31'b0, ready_b}, 32'h1);
        hread(13'h17FC); chk("R8 ctrl0", ra, 32'h8);
    endtask

    task automatic t_mismatch;
        load_unicast(8, 8'hD0);
        fbuf[5] = 8'h56;
        send(8);
        hread(13'h17FC); chk("R1 drop ctrl0", ra, 32'h8);
        chk("R1 drop ctrl0 fixed", rb, 32'h8);
        hread(13'h1000); chk("R1 drop word0", ra, 32'h33221102);
        chk("R1 drop ready", {31'b0, ready_a}, 32'h1);
    endtask

    task automatic t_short;
        for (int i = 0; i < 4; i++) fbuf[i] = 8'hFF;
        send(4);
        hread(13'h17FC); chk("R9 short ctrl0", ra, 32'h8);
        chk("R9 short irq", 32'(irqs_a), 32'd1);
    endtask

    task automatic t_gie_off;
        glb_irq_en = 1'b0;
        load_unicast(6, 8'h00);
        send(6);
        chk("R5 gie off", 32'(irqs_a), 32'd1);
        hread(13'h17FC); chk("R4 ctrl0 again", ra, 32'h9);
        chk("R6 fixed slot0", rb, 32'h9);
        hread(13'h1004); chk("R4 new tail", ra, 32'h00005544);
        chk("R6 ready next full", {31'b0, ready_a}, 32'h0);
        glb_irq_en = 1'b1;
    endtask

    task automatic t_length;
        hwrite(13'h17FC, 32'h0);
        hwrite(13'h1FFC, 32'h0);
        for (int i = 0; i < 2020; i++) fbuf[i] = (i < 6) ? 8'hFF : 8'(i);
        send(2020);
        hread(13'h1FFC); chk("R3 too long ctrl1", ra, 32'h0);
        hread(13'h17FC); chk("R3 too long fixed", rb, 32'h0);
        send(2019);
        hread(13'h1FFC); chk("R3 max ctrl1", ra, 32'h1);
        hread(13'h1FE0); chk("R3 max last word", ra, 32'h00E2E1E0);
        hread(13'h17FC); chk("R6 fixed ctrl0", rb, 32'h1);
        hread(13'h17E0); chk("R3 fixed last word", rb, 32'h00E2E1E0);
        chk("R6 ready slot0", {31'b0, ready_a}, 32'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R7 watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        t_reset;
        t_unicast;
        t_group;
        t_full;
        t_free;
        t_mismatch;
        t_short;
        t_gie_off;
        t_length;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule